// File: doc/BRIEF.md
# Host Bus Burst FIFO Read Port

This block is the read side of a slave port on an asynchronous parallel host bus. A CPU reads a 32-bit receive FIFO in burst mode. It uses an active-low chip select, an active-low read strobe, an active-high FIFO-select line and one address bit. All four host inputs pass through a multi-flop synchronizer into the system clock. A burst cycle is framed only by the combined state of the two strobes. The strobes may rise and fall in any order.

When a cycle opens, the word at the FIFO head is latched onto the data output without a pop. Each later change of the address bit, rising or falling, pops the word on show. The next head word then appears on the output. The block also drives the enable of the tri-stated data bus. If a pop is asked for while the FIFO is empty, no pop is issued. The last data stays on the output and a sticky underflow flag is raised.

Top module: `hbr_burst_rd_port`

## Requirements
- R1: While reset is asserted and right after it is released, `data_oe_o`, `fifo_pop_o` and `underflow_o` are all 0.
- R2: A cycle opens, and `data_oe_o` goes to 1, only when `cs_ni` and `rd_ni` are both 0 and `fsel_i` is 1. A single low strobe, whichever one it is, leaves `data_oe_o` at 0.
- R3: Raising either `cs_ni` or `rd_ni` closes the cycle, and `data_oe_o` returns to 0.
- R4: At the opening of a cycle, `data_o` takes the current FIFO head word and no pop is issued. A word left unpopped at the end of one cycle is shown again at the start of the next.
- R5: Within an open cycle, each level change of `a2_i` (0 to 1 or 1 to 0) pops the FIFO. After the pop, `data_o` shows the new head word. Across a run of cycles, the host sees the FIFO words in order, each exactly once per presentation.
- R6: Changes of `a2_i` while no cycle is open issue no pop and do not advance the data.
- R7: A change of `a2_i` while `fifo_empty_i` is 1 issues no pop and keeps `data_o` unchanged. It also sets `underflow_o`, which stays 1 until reset.
- R8: `fifo_pop_o` is asserted only while `data_oe_o` is 1, and for exactly one clock per accepted change of `a2_i`.
- R9: While `fsel_i` is 0, no cycle opens even with both strobes low, and changes of `a2_i` issue no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host chip select, active low, asynchronous |
| rd_ni | input | 1 | Host read strobe, active low, asynchronous |
| fsel_i | input | 1 | Direct FIFO access select, active high, asynchronous |
| a2_i | input | 1 | Host address bit whose changes step the burst |
| fifo_rdata_i | input | 32 | FIFO head word (first-word-fall-through) |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | One-clock pop request to the FIFO |
| data_o | output | 32 | Word for the host data bus |
| data_oe_o | output | 1 | Output enable for the tri-stated host data bus |
| underflow_o | output | 1 | Sticky flag: a pop was requested while the FIFO was empty |

## Verification
The assertions check four rules on every clock:
- a pop only occurs while the bus is driven;
- the cycle start never carries a pop;
- dropping either synchronized strobe, or FIFO-select, disables the driver on the next edge;
- the underflow flag never clears.

Only the bench scenarios can show the rest: the order of words seen by the host across cycles, that a word left unpopped is presented again, strobe ordering in both directions, and that address changes outside a cycle have no effect. They also show the output hold and the single pop count when the FIFO runs dry.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

  // Synchronized host-side control lines.
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic fsel;
    logic a2;
  } host_ctl_t;

  localparam int unsigned HOST_CTL_W = $bits(host_ctl_t);

  // Idle levels: strobes inactive, select off, address low.
  localparam host_ctl_t HOST_CTL_IDLE = '{cs_n: 1'b1, rd_n: 1'b1, fsel: 1'b0, a2: 1'b0};

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hbr_frame.sv
module hbr_frame
  import hbr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  host_ctl_t ctl_i,
  output logic      start_o,
  output logic      step_o,
  output logic      oe_o
);

  logic cyc_s;
  logic act_q;
  logic a2_q;

  // Framing depends only on the combined strobe state, so order is irrelevant.
  assign cyc_s = !ctl_i.cs_n && !ctl_i.rd_n && ctl_i.fsel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      a2_q  <= 1'b0;
    end else begin
      act_q <= cyc_s;
      a2_q  <= ctl_i.a2;
    end
  end

  assign start_o = cyc_s && !act_q;
  // An address change coinciding with the opening edge is absorbed by the start.
  assign step_o  = cyc_s && act_q && (ctl_i.a2 ^ a2_q);
  assign oe_o    = act_q;

  a_r2_oe_needs_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> ($past(!ctl_i.cs_n) && $past(!ctl_i.rd_n)));

endmodule

// File: rtl/hbr_rd_path.sv
module hbr_rd_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic              fifo_empty_i,
  output logic              pop_o,
  output logic [DATA_W-1:0] data_o,
  output logic              underflow_o
);

  logic              pop_q;
  logic              ld_q;
  logic              und_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_q <= 1'b0;
      ld_q  <= 1'b0;
      und_q <= 1'b0;
    end else begin
      pop_q <= step_i && !fifo_empty_i;
      // The FIFO head advances at the edge that samples the pop; reload after that.
      ld_q  <= pop_q;
      if (step_i && fifo_empty_i) und_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               data_q <= '0;
    else if (start_i || ld_q)  data_q <= fifo_rdata_i;
  end

  assign pop_o       = pop_q;
  assign data_o      = data_q;
  assign underflow_o = und_q;

  a_r7_sticky_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    und_q |=> und_q);

  a_r7_hold_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && fifo_empty_i && !start_i && !ld_q) |=> $stable(data_q));

endmodule

// File: rtl/hbr_burst_rd_port.sv
module hbr_burst_rd_port
  import hbr_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              fsel_i,
  input  logic              a2_i,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              underflow_o
);

  host_ctl_t ctl_raw;
  host_ctl_t ctl_s;
  logic      start;
  logic      step;

  assign ctl_raw = '{cs_n: cs_ni, rd_n: rd_ni, fsel: fsel_i, a2: a2_i};

  hbr_sync #(
    .WIDTH  (HOST_CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(HOST_CTL_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctl_raw),
    .q_o   (ctl_s)
  );

  hbr_frame u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_s),
    .start_o(start),
    .step_o (step),
    .oe_o   (data_oe_o)
  );

  hbr_rd_path #(
    .DATA_W(DATA_W)
  ) u_rd_path (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .step_i      (step),
    .fifo_rdata_i(fifo_rdata_i),
    .fifo_empty_i(fifo_empty_i),
    .pop_o       (fifo_pop_o),
    .data_o      (data_o),
    .underflow_o (underflow_o)
  );

  a_r8_pop_in_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> data_oe_o);

  a_r4_start_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> !fifo_pop_o);

  a_r3_strobe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_s.cs_n || ctl_s.rd_n) |=> !data_oe_o);

  a_r9_no_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_s.fsel |=> !data_oe_o);

endmodule

// File: tb/tb_hbr_burst_rd_port.sv
`timescale 1ns/1ps
module tb_hbr_burst_rd_port;

  localparam int AVAIL = 6;
  localparam logic [31:0] EMPTY_WORD = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, fsel = 1'b0, a2 = 1'b0;
  logic [31:0] rdata;
  logic        empty;
  logic        pop;
  logic [31:0] data;
  logic        oe;
  logic        und;

  int n_chk = 0, n_err = 0;
  int hd = 0, pop_cnt = 0, rd_idx = 0;
  logic [31:0] exp_q[$];
  logic        oe_prev = 1'b0;
  logic [31:0] d_prev = '0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] word_at(int i);
    return 32'hA500_0000 + i * 32'h0011_0203 + 32'h5;
  endfunction

  // FIFO model: first-word-fall-through
  assign rdata = (hd < AVAIL) ? word_at(hd) : EMPTY_WORD;
  assign empty = (hd >= AVAIL);
  always @(posedge clk) if (pop) begin hd <= hd + 1; pop_cnt <= pop_cnt + 1; end

  hbr_burst_rd_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .fsel_i(fsel),
    .a2_i(a2), .fifo_rdata_i(rdata), .fifo_empty_i(empty), .fifo_pop_o(pop),
    .data_o(data), .data_oe_o(oe), .underflow_o(und)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: every new presentation on the bus is compared with the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (oe && (!oe_prev || data != d_prev)) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", data, '0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R4/R5 word order", data, e);
        end
      end
      oe_prev = oe;
      d_prev  = data;
    end
  end

  task automatic start_cyc(bit cs_first);
    fsel = 1'b1;
    settle(1);
    if (cs_first) cs_n = 1'b0; else rd_n = 1'b0;
    settle(5);
    chk(oe == 1'b0, "R2 one strobe", oe, 0);
    exp_q.push_back(rd_idx < AVAIL ? word_at(rd_idx) : EMPTY_WORD);
    if (cs_first) rd_n = 1'b0; else cs_n = 1'b0;
    settle(6);
    chk(oe == 1'b1, "R2 both strobes", oe, 1);
  endtask

  task automatic step_a2();
    a2 = ~a2;
    if (rd_idx < AVAIL) begin
      rd_idx++;
      exp_q.push_back(rd_idx < AVAIL ? word_at(rd_idx) : EMPTY_WORD);
    end
    settle(7);
  endtask

  task automatic end_cyc(bit by_cs);
    if (by_cs) cs_n = 1'b1; else rd_n = 1'b1;
    settle(5);
    chk(oe == 1'b0, "R3 release", oe, 0);
    cs_n = 1'b1; rd_n = 1'b1;
    settle(4);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    settle(3);
    chk(oe == 1'b0 && pop == 1'b0 && und == 1'b0, "R1 in reset", {oe, pop, und}, 0);
    rst_n = 1'b1;
    settle(3);
    chk(oe == 1'b0 && pop == 1'b0 && und == 1'b0, "R1 after reset", {oe, pop, und}, 0);

    // Cycle 1: cs first, three steps, closed by read strobe
    start_cyc(1'b1);
    chk(pop_cnt == 0, "R4 no pop at start", pop_cnt, 0);
    step_a2(); step_a2(); step_a2();
    chk(pop_cnt == 3, "R5 pops per step", pop_cnt, 3);
    end_cyc(1'b0);

    // Address activity with no cycle open
    a2 = ~a2; settle(6);
    a2 = ~a2; settle(6);
    chk(pop_cnt == 3, "R6 idle steps ignored", pop_cnt, 3);
    chk(oe == 1'b0, "R6 bus idle", oe, 0);

    // Cycle 2: read first, unpopped head re-presented, closed by chip select
    start_cyc(1'b0);
    step_a2(); step_a2();
    chk(pop_cnt == 5, "R5 pops in cycle 2", pop_cnt, 5);
    end_cyc(1'b1);

    // FIFO-select low: no cycle and no pops
    fsel = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
    settle(6);
    chk(oe == 1'b0, "R9 no cycle without select", oe, 0);
    a2 = ~a2; settle(6);
    chk(pop_cnt == 5, "R9 no pop without select", pop_cnt, 5);
    cs_n = 1'b1; rd_n = 1'b1;
    settle(4);

    // Cycle 3: drain and underflow
    start_cyc(1'b1);
    step_a2();
    chk(pop_cnt == 6 && und == 1'b0, "R5 last pop", pop_cnt, 6);
    step_a2();
    chk(und == 1'b1, "R7 underflow set", und, 1);
    chk(pop_cnt == 6, "R7 no pop when empty", pop_cnt, 6);
    chk(data == EMPTY_WORD, "R7 data held", data, EMPTY_WORD);
    end_cyc(1'b0);
    settle(4);
    chk(und == 1'b1, "R7 sticky", und, 1);
    chk(pop_cnt == rd_idx, "R8 one pop per accepted step", pop_cnt, rd_idx);
    chk(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  // R8: pop must never be seen outside a driven cycle
  always @(negedge clk) if (rst_n && pop && !oe) chk(1'b0, "R8 pop outside cycle", pop, 0);

endmodule